// File: doc/BRIEF.md
# Four-Way Pseudo-LRU Victim Tracker

This block keeps the recency order of a four-entry fully associative instruction translation buffer. The order lives in a 6-bit field, one bit per pair of entries. Each bit records which entry of its pair was used more recently. When an entry is hit, the field is updated with a fixed clear/set mask for that entry. When an entry is refilled, the same update is applied to the entry that was picked as the victim. Tag storage and lookup belong to the surrounding logic.

The field is decoded every cycle into the index of the entry to evict next. A field that names no entry raises an error flag. Software can read the field at any time and can overwrite it. A software write beats any hardware update in the same cycle.

Field encoding: field bit `n` stands for bit `n+2` of an 8-bit word whose two low bits are zero. All masks below are written on that 8-bit word.

Top module: `plru4_tracker`

## Requirements
- R1: After reset the field is 0, the victim index is 3 and the error flag is low.
- R2: A use of entry 0 ANDs the word with 0x1F.
- R3: A use of entry 1 ANDs the word with 0xE7 and then ORs in 0x80.
- R4: A use of entry 2 ANDs the word with 0xFB and then ORs in 0x50.
- R5: A use of entry 3 ORs the word with 0x2C and leaves every other bit unchanged.
- R6: The victim index is decoded combinationally from the current field. It is 0 when (word & 0xE0) == 0xE0, else 1 when (word & 0x98) == 0x18, else 2 when (word & 0x54) == 0x04, else 3 when (word & 0x2C) == 0x00.
- R7: When none of the R6 patterns matches, the error flag is high and the victim index reads 0.
- R8: A refill strobe applies the use update of the entry currently shown as the victim.
- R9: When a refill and a hit are strobed in the same cycle, only the refill update is applied.
- R10: A software write loads the field in the next cycle and overrides any hit or refill in the same cycle.
- R11: Starting from reset, after any sequence of uses the victim index is the least recently used entry.
- R12: With no strobe the field holds its value, and the field output always shows the stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_valid | input | 1 | Hit on an entry this cycle |
| use_idx | input | 2 | Entry that was hit |
| refill_valid | input | 1 | The current victim entry is being refilled |
| sw_wr_en | input | 1 | Software write of the field |
| sw_wr_data | input | 6 | Value to load into the field |
| lru_field | output | 6 | Current field, for software reads |
| repl_idx | output | 2 | Entry to evict next |
| repl_err | output | 1 | Field matches no victim pattern |

## Verification
The assertions assume that the strobes are two-state after reset. They also assume that the victim-change checks only hold while the field is decodable. For that reason, the refill property is qualified by a low error flag. The hit property accepts either a different index or a raised error flag.

The directed tasks drive every input on the falling edge. Error-state fields are loaded only through the software write port. This keeps the LRU-order scenario inside states that can be reached from reset.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
    localparam int NUM_WAYS = 4;
    localparam int IDX_W    = $clog2(NUM_WAYS);
    localparam int FIELD_W  = NUM_WAYS * (NUM_WAYS - 1) / 2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [IDX_W-1:0]   way_t;

    typedef struct packed {
        field_t field;
    } plru_state_t;

    // Pair (a,b), a<b, is numbered in lexical order; pair 0 is the top bit.
    // A set bit means b was used after a.
    function automatic int pair_pos(input int a, input int b);
        int n;
        int pos;
        n   = 0;
        pos = 0;
        for (int x = 0; x < NUM_WAYS; x++) begin
            for (int y = x + 1; y < NUM_WAYS; y++) begin
                if (x == a && y == b) pos = n;
                n++;
            end
        end
        return FIELD_W - 1 - pos;
    endfunction

    // Bits that become 1 when way k is used: pairs where k is the later member.
    function automatic field_t newer_mask(input int k);
        field_t m;
        m = '0;
        for (int i = 0; i < k; i++) m[pair_pos(i, k)] = 1'b1;
        return m;
    endfunction

    // Bits that become 0 when way k is used: pairs where k is the earlier member.
    function automatic field_t older_mask(input int k);
        field_t m;
        m = '0;
        for (int j = k + 1; j < NUM_WAYS; j++) m[pair_pos(k, j)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/plru4_update.sv
module plru4_update
    import plru4_pkg::*;
(
    input  field_t cur_field,
    input  logic   upd_en,
    input  way_t   upd_way,
    output field_t nxt_field
);
    field_t set_tbl [NUM_WAYS];
    field_t clr_tbl [NUM_WAYS];

    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_mask
        assign set_tbl[k] = newer_mask(k);
        assign clr_tbl[k] = older_mask(k);
    end

    always_comb begin
        nxt_field = cur_field;
        if (upd_en) begin
            nxt_field = (cur_field & ~clr_tbl[upd_way]) | set_tbl[upd_way];
        end
    end
endmodule

// File: rtl/plru4_decode.sv
module plru4_decode
    import plru4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  field_t field,
    output way_t   victim,
    output logic   no_match
);
    logic [NUM_WAYS-1:0] hit_vec;

    // Way k is oldest when every other way is newer: pairs (i,k) read 0, pairs (k,j) read 1.
    for (genvar k = 0; k < NUM_WAYS; k++) begin : g_match
        localparam field_t CARE = newer_mask(k) | older_mask(k);
        localparam field_t WANT = older_mask(k);
        assign hit_vec[k] = ((field & CARE) == WANT);
    end

    always_comb begin
        victim = '0;
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            if (hit_vec[k]) victim = way_t'(k);
        end
        no_match = ~|hit_vec;
    end

    // R6: the per-way patterns never overlap, so the checking order cannot matter
    a_r6_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/plru4_tracker.sv
module plru4_tracker
    import plru4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_valid,
    input  logic [1:0] use_idx,
    input  logic       refill_valid,
    input  logic       sw_wr_en,
    input  logic [5:0] sw_wr_data,
    output logic [5:0] lru_field,
    output logic [1:0] repl_idx,
    output logic       repl_err
);
    plru_state_t state_q, state_d;
    logic        upd_en;
    way_t        upd_way;
    field_t      upd_field;
    way_t        victim;
    logic        no_match;

    // Refill (R8) outranks a hit (R9).
    assign upd_en  = refill_valid | use_valid;
    assign upd_way = refill_valid ? victim : use_idx;

    plru4_update u_update (
        .cur_field (state_q.field),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .nxt_field (upd_field)
    );

    plru4_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .field    (state_q.field),
        .victim   (victim),
        .no_match (no_match)
    );

    always_comb begin
        state_d       = state_q;
        state_d.field = upd_field;
        if (sw_wr_en) begin
            state_d.field = sw_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lru_field = state_q.field;
    assign repl_idx  = victim;
    assign repl_err  = no_match;

    // R10: software write lands regardless of concurrent strobes
    a_r10_sw_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> lru_field == $past(sw_wr_data));

    // R12: nothing strobed, nothing changes
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !use_valid && !refill_valid) |=> $stable(lru_field));

    // R11: a just-used way is never the next victim
    a_r11_used_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && use_valid && !refill_valid)
        |=> (repl_idx != $past(use_idx)) || repl_err);

    // R8: refilling the victim moves the victim elsewhere
    a_r8_refill_moves_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && refill_valid && !repl_err) |=> repl_idx != $past(repl_idx));
endmodule

// File: tb/plru4_tracker_tb.sv
module plru4_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       use_valid;
    logic [1:0] use_idx;
    logic       refill_valid;
    logic       sw_wr_en;
    logic [5:0] sw_wr_data;
    logic [5:0] lru_field;
    logic [1:0] repl_idx;
    logic       repl_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    plru4_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .use_valid(use_valid), .use_idx(use_idx),
        .refill_valid(refill_valid), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .lru_field(lru_field), .repl_idx(repl_idx), .repl_err(repl_err)
    );

    function automatic logic [5:0] ref_use(input logic [5:0] f, input logic [1:0] k);
        logic [7:0] w;
        w = {f, 2'b00};
        case (k)
            2'd0: w = w & 8'h1F;
            2'd1: w = (w & 8'hE7) | 8'h80;
            2'd2: w = (w & 8'hFB) | 8'h50;
            default: w = w | 8'h2C;
        endcase
        return w[7:2];
    endfunction

    // returns {err, idx}
    function automatic logic [2:0] ref_dec(input logic [5:0] f);
        logic [7:0] w;
        w = {f, 2'b00};
        if ((w & 8'hE0) == 8'hE0)      return 3'b000;
        else if ((w & 8'h98) == 8'h18) return 3'b001;
        else if ((w & 8'h54) == 8'h04) return 3'b010;
        else if ((w & 8'h2C) == 8'h00) return 3'b011;
        return 3'b100;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        use_valid = 0; refill_valid = 0; sw_wr_en = 0; use_idx = 0; sw_wr_data = 0;
    endtask

    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic sw_load(input logic [5:0] v);
        @(negedge clk); sw_wr_en = 1; sw_wr_data = v;
        cycle();
    endtask

    task automatic hit(input logic [1:0] k);
        @(negedge clk); use_valid = 1; use_idx = k;
        cycle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; idle();
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 field", {2'b0, lru_field}, 8'h00);
        check("R1 idx", {6'b0, repl_idx}, 8'd3);
        check("R1 err", {7'b0, repl_err}, 8'd0);
    endtask

    task automatic t_masks();
        logic [5:0] seeds [3] = '{6'h3F, 6'h00, 6'h15};
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                sw_load(seeds[s]);
                hit(2'(k));
                case (k)
                    0: check("R2 use0", {2'b0, lru_field}, {2'b0, ref_use(seeds[s], 2'd0)});
                    1: check("R3 use1", {2'b0, lru_field}, {2'b0, ref_use(seeds[s], 2'd1)});
                    2: check("R4 use2", {2'b0, lru_field}, {2'b0, ref_use(seeds[s], 2'd2)});
                    default: check("R5 use3", {2'b0, lru_field}, {2'b0, ref_use(seeds[s], 2'd3)});
                endcase
            end
        end
    endtask

    task automatic t_decode();
        for (int v = 0; v < 64; v++) begin
            logic [2:0] e;
            sw_load(6'(v));
            e = ref_dec(6'(v));
            check("R12 readback", {2'b0, lru_field}, 8'(v));
            if (e[2]) begin
                check("R7 err", {7'b0, repl_err}, 8'd1);
                check("R7 idx", {6'b0, repl_idx}, 8'd0);
            end else begin
                check("R6 err", {7'b0, repl_err}, 8'd0);
                check("R6 idx", {6'b0, repl_idx}, {6'b0, e[1:0]});
            end
        end
    endtask

    task automatic t_refill();
        logic [1:0] v;
        do_reset();
        hit(2'd1);
        v = repl_idx;
        @(negedge clk); refill_valid = 1;
        cycle();
        check("R8 refill", {2'b0, lru_field}, {2'b0, ref_use(ref_use(6'h00, 2'd1), v)});
        sw_load(6'h00);
        @(negedge clk); refill_valid = 1; use_valid = 1; use_idx = 2'd0;
        cycle();
        check("R9 refill wins", {2'b0, lru_field}, {2'b0, ref_use(6'h00, 2'd3)});
    endtask

    task automatic t_sw_priority();
        sw_load(6'h00);
        @(negedge clk); use_valid = 1; use_idx = 2'd2; sw_wr_en = 1; sw_wr_data = 6'h2A;
        cycle();
        check("R10 over hit", {2'b0, lru_field}, 8'h2A);
        @(negedge clk); refill_valid = 1; sw_wr_en = 1; sw_wr_data = 6'h07;
        cycle();
        check("R10 over refill", {2'b0, lru_field}, 8'h07);
        cycle(); cycle();
        check("R12 hold", {2'b0, lru_field}, 8'h07);
    endtask

    task automatic t_lru_order();
        int ord [4];
        logic [31:0] lfsr = 32'h1234_5678;
        do_reset();
        ord = '{0, 1, 2, 3};
        for (int n = 0; n < 200; n++) begin
            int k;
            int p;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            k = int'(lfsr[1:0]);
            if (lfsr[7:5] == 3'd0) begin
                k = int'(repl_idx);
                @(negedge clk); refill_valid = 1;
                cycle();
            end else begin
                hit(2'(k));
            end
            p = 0;
            for (int i = 0; i < 4; i++) if (ord[i] == k) p = i;
            for (int i = 3; i > 0; i--) if (i <= p) ord[i] = ord[i-1];
            ord[0] = k;
            check("R11 lru", {6'b0, repl_idx}, 8'(ord[3]));
            check("R11 err", {7'b0, repl_err}, 8'd0);
        end
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle();
        t_reset();
        t_masks();
        t_decode();
        t_refill();
        t_sw_priority();
        t_lru_order();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule